// File: doc/BRIEF.md
# Inbound Write Burst Posting Bridge

This block is the target side of a bridge that takes memory write bursts from a simplified parallel bus and posts them toward a host. Each bus transaction opens with one address cycle that carries a dword address and a command flag. The command is either a plain memory write or a write-and-invalidate. Data beats of 32 bits with byte enables follow. For each offered beat the target answers with accept, accept-and-disconnect, or, before any beat has been taken, retry.

Accepted data is gathered in a one-line (32-byte) assembly buffer. It is then posted into an in-order request queue toward the host.

- Plain writes leave as partial requests covering at most one aligned 8-byte chunk.
- Write-and-invalidate bursts are combined into full 32-byte line requests.

The bridge cuts a burst short in four cases: the queue is about to run out, the host side has outbound traffic pending, a 4 KB page ends, or a combined line cannot be completed. A first-beat latency timer forces a retry when no beat can be taken in time.

Top module: `wpb_bridge`

## Requirements
- R1: After reset, tgt_ack, tgt_disc, tgt_retry and hreq_valid are all low.
- R2: A beat is accepted only while the request queue has a free entry and no leftover drain is running. A beat whose request fills the last free entry, with no host accept in that cycle, is accepted with tgt_disc, and the transaction ends there. This applies whatever the command.
- R3: A beat accepted while host_out_pend is high is accepted with tgt_disc, and the transaction ends.
- R4: A beat whose dword address is the last dword of a 4 KB page (dword address bits [9:0] all ones) is accepted with tgt_disc. The next beat is not accepted in that transaction.
- R5: With bus_mwi=0, each beat at an odd dword offset posts one request with hreq_line=0. Its mask covers only the supplied bytes of that aligned 8-byte chunk. The request uses these encodings:
  - hreq_line_addr is the byte address divided by 32.
  - Mask bit n is byte n of the line.
  - hreq_data bits [8n+7:8n] hold byte n.
- R6: With bus_mwi=1, a request with hreq_line=1 is posted when the beat at line offset 7 completes a line whose eight dwords were all supplied. Its mask is the collected byte enables.
- R7: Data left in the assembly buffer is drained as partial requests, one per 8-byte chunk holding data, lowest chunk first. This happens when a burst ends early, and also at offset 7 of an incomplete write-and-invalidate line, where that beat is disconnected. No beat is accepted while the drain runs.
- R8: If no beat is accepted in the first 16 cycles after the address cycle, tgt_retry is high in the 16th cycle without accepting a beat. The transaction then ends.
- R9: The latency timer restarts at every address cycle and stops once the first beat is accepted. Later idle cycles in the same transaction never cause a retry.
- R10: A request stays valid and unchanged until hreq_ready. Requests leave in the order they were posted, and each accept frees one entry.
- R11: After a beat ends a transaction (bus_last or tgt_disc) or after a retry, no beat is accepted until a new address cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Address cycle strobe, taken when no transaction is open |
| bus_dwaddr | input | 30 | Starting dword address (byte address / 4) |
| bus_mwi | input | 1 | 1 = write-and-invalidate, 0 = plain memory write |
| bus_dvalid | input | 1 | Master offers a data beat |
| bus_data | input | 32 | Beat data |
| bus_be | input | 4 | Beat byte enables, active high |
| bus_last | input | 1 | Offered beat is the master's final one |
| host_out_pend | input | 1 | Host side has outbound traffic waiting |
| tgt_ack | output | 1 | Offered beat accepted this cycle |
| tgt_disc | output | 1 | Accepted beat is the last of the transaction |
| tgt_retry | output | 1 | Transaction ended with no beat accepted |
| hreq_valid | output | 1 | Head request valid |
| hreq_ready | input | 1 | Host accepts the head request |
| hreq_line_addr | output | 27 | Line address (byte address / 32) |
| hreq_data | output | 256 | Line data, byte n at bits [8n+7:8n] |
| hreq_mask | output | 32 | Byte mask, bit n = byte n |
| hreq_line | output | 1 | 1 = full line write, 0 = partial write |

## Verification
The bench builds the block with a request queue of depth 4, a 16-cycle first-beat limit and a 4 KB page. With a depth of 4, eight plain beats reach the queue-full disconnect. The same small queue can also be left nearly full, so a leftover drain stalls and blocks the next transaction long enough to force the retry. Bursts started two dwords before a page end, and write-and-invalidate bursts started mid-line, reach the page and incomplete-line cut-offs in a handful of beats.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  localparam int ADDR_W      = 32;
  localparam int DWA_W       = ADDR_W - 2;
  localparam int LA_W        = ADDR_W - 5;
  localparam int BEAT_W      = 32;
  localparam int BE_W        = BEAT_W / 8;
  localparam int LINE_DWORDS = 8;
  localparam int LINE_BITS   = BEAT_W * LINE_DWORDS;
  localparam int LINE_BYTES  = LINE_BITS / 8;

  typedef struct packed {
    logic [LA_W-1:0]       tag;
    logic [LINE_BITS-1:0]  data;
    logic [LINE_BYTES-1:0] mask;
    logic                  line;
  } host_req_t;

  // byte lanes of one aligned 8-byte chunk inside a line
  function automatic logic [LINE_BYTES-1:0] chunk_mask(input logic [1:0] c);
    return 32'h0000_00FF << {c, 3'b000};
  endfunction

  // dword address is the final dword of a 2**pw byte page
  function automatic logic page_last(input logic [DWA_W-1:0] dw, input int pw);
    logic [DWA_W-1:0] m;
    m = (30'h1 << (pw - 2)) - 30'h1;
    return (dw & m) == m;
  endfunction

  function automatic logic one_chunk(input logic [LINE_BYTES-1:0] m);
    logic hit;
    hit = 1'b0;
    for (int c = 0; c < 4; c++)
      if ((m & ~chunk_mask(2'(c))) == '0) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/wpb_req_queue.sv
module wpb_req_queue
  import wpb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  host_req_t     push_req,
  input  logic          pop,
  output host_req_t     head,
  output logic          not_empty,
  output logic [CW-1:0] used
);
  host_req_t        mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  assign head      = mem[rd_ptr];
  assign not_empty = (used != '0);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) if (push) mem[wr_ptr] <= push_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; used <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      used <= used + 1'b1;
      else if (pop && !push) used <= used - 1'b1;
    end
  end

  AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> used < CW'(DEPTH)); // R2
  AST_QUEUE_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty); // R10
endmodule

// File: rtl/wpb_target_ctl.sv
module wpb_target_ctl
  import wpb_pkg::*;
#(
  parameter int RETRY_CLKS = 16,
  parameter int PAGE_W = 12,
  localparam int LW = $clog2(RETRY_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic [DWA_W-1:0] bus_dwaddr,
  input  logic             bus_mwi,
  input  logic             bus_dvalid,
  input  logic             bus_last,
  input  logic             host_out_pend,
  input  logic             q_room,
  input  logic             q_last_slot,
  input  logic             drain_busy,
  input  logic             would_push,
  input  logic             line_gap,
  output logic             tgt_ack,
  output logic             tgt_disc,
  output logic             tgt_retry,
  output logic [DWA_W-1:0] beat_dw,
  output logic             mode_mwi,
  output logic             beat_end
);
  logic          active, got_beat;
  logic [LW-1:0] lat;
  logic          page_end, slot_out, late;

  assign page_end  = page_last(beat_dw, PAGE_W);
  assign slot_out  = would_push && q_last_slot;
  assign late      = (lat == LW'(RETRY_CLKS - 1));
  assign tgt_ack   = active && bus_dvalid && q_room && !drain_busy;
  assign tgt_disc  = tgt_ack && (host_out_pend || page_end || line_gap || slot_out);
  assign beat_end  = tgt_ack && (bus_last || tgt_disc);
  assign tgt_retry = active && !got_beat && !tgt_ack && late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; got_beat <= 1'b0; lat <= '0; beat_dw <= '0; mode_mwi <= 1'b0;
    end else if (!active) begin
      if (bus_start) begin
        active <= 1'b1; got_beat <= 1'b0; lat <= '0;
        beat_dw <= bus_dwaddr; mode_mwi <= bus_mwi;
      end
    end else if (tgt_ack) begin
      beat_dw  <= beat_dw + 1'b1;
      got_beat <= 1'b1;
      if (beat_end) active <= 1'b0;
    end else if (tgt_retry) begin
      active <= 1'b0;
    end else if (!got_beat) begin
      lat <= lat + 1'b1;
    end
  end

  AST_END_STOPS_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_end |=> !tgt_ack); // R11
  AST_RETRY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_retry |=> !tgt_ack && !tgt_retry); // R8
  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active && !got_beat |-> lat < LW'(RETRY_CLKS)); // R8
  AST_NO_RETRY_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    got_beat |-> !tgt_retry); // R9
endmodule

// File: rtl/wpb_line_packer.sv
module wpb_line_packer
  import wpb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_take,
  input  logic              beat_end,
  input  logic              mwi,
  input  logic              q_room,
  input  logic [DWA_W-1:0]  beat_dw,
  input  logic [BEAT_W-1:0] beat_data,
  input  logic [BE_W-1:0]   beat_be,
  output logic              would_push,
  output logic              line_gap,
  output logic              drain_busy,
  output logic              push,
  output host_req_t         push_req
);
  logic [LINE_BITS-1:0]   buf_data, m_data;
  logic [LINE_BYTES-1:0]  buf_be, m_be;
  logic [LINE_DWORDS-1:0] buf_dv, m_dv, dr_dv;
  logic [LA_W-1:0]        buf_tag;
  logic [2:0]             off;
  logic [1:0]             dr_chunk;
  logic                   full_line, pair_done, beat_push, drain_push;

  assign off = beat_dw[2:0];

  always_comb begin
    m_data = buf_data;
    m_data[{off, 5'b0} +: BEAT_W] = beat_data;
    m_be = buf_be;
    m_be[{off, 2'b0} +: BE_W] = beat_be;
    m_dv = buf_dv;
    m_dv[off] = 1'b1;
  end

  assign full_line  = mwi && (off == 3'd7) && (&m_dv);
  assign line_gap   = mwi && (off == 3'd7) && !(&m_dv);
  assign pair_done  = !mwi && off[0];
  assign would_push = full_line || pair_done;
  assign beat_push  = beat_take && would_push;
  assign drain_push = drain_busy && q_room;
  assign push       = beat_push || drain_push;

  always_comb begin
    dr_chunk = 2'd0;
    for (int c = 3; c >= 0; c--)
      if (buf_dv[2*c +: 2] != 2'b00) dr_chunk = 2'(c);
  end
  assign dr_dv = 8'b0000_0011 << {dr_chunk, 1'b0};

  always_comb begin
    push_req.line = beat_push && full_line;
    if (beat_push) begin
      push_req.tag  = beat_dw[DWA_W-1:3];
      push_req.data = m_data;
      push_req.mask = full_line ? m_be : (m_be & chunk_mask(off[2:1]));
    end else begin
      push_req.tag  = buf_tag;
      push_req.data = buf_data;
      push_req.mask = buf_be & chunk_mask(dr_chunk);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_data <= '0; buf_be <= '0; buf_dv <= '0; buf_tag <= '0; drain_busy <= 1'b0;
    end else if (beat_take) begin
      buf_tag <= beat_dw[DWA_W-1:3];
      if (would_push) begin
        buf_dv <= '0; buf_be <= '0;
      end else begin
        buf_dv <= m_dv; buf_be <= m_be; buf_data <= m_data;
      end
      drain_busy <= beat_end && !would_push;
    end else if (drain_push) begin
      buf_dv     <= buf_dv & ~dr_dv;
      buf_be     <= buf_be & ~chunk_mask(dr_chunk);
      drain_busy <= (buf_dv & ~dr_dv) != '0;
    end
  end

  AST_DRAIN_BLOCKS_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy |-> !beat_take); // R7
  AST_DRAIN_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy |-> buf_dv != '0); // R7
endmodule

// File: rtl/wpb_bridge.sv
module wpb_bridge
  import wpb_pkg::*;
#(
  parameter int Q_DEPTH = 4,
  parameter int RETRY_CLKS = 16,
  parameter int PAGE_W = 12,
  localparam int CW = $clog2(Q_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_start,
  input  logic [DWA_W-1:0]      bus_dwaddr,
  input  logic                  bus_mwi,
  input  logic                  bus_dvalid,
  input  logic [BEAT_W-1:0]     bus_data,
  input  logic [BE_W-1:0]       bus_be,
  input  logic                  bus_last,
  input  logic                  host_out_pend,
  output logic                  tgt_ack,
  output logic                  tgt_disc,
  output logic                  tgt_retry,
  output logic                  hreq_valid,
  input  logic                  hreq_ready,
  output logic [LA_W-1:0]       hreq_line_addr,
  output logic [LINE_BITS-1:0]  hreq_data,
  output logic [LINE_BYTES-1:0] hreq_mask,
  output logic                  hreq_line
);
  logic             q_pop, q_room, q_last_slot, push, would_push, line_gap;
  logic             drain_busy, mode_mwi, beat_end;
  logic [CW-1:0]    q_used;
  logic [DWA_W-1:0] beat_dw;
  host_req_t        push_req, head;

  assign q_pop       = hreq_valid && hreq_ready;
  assign q_room      = q_used < CW'(Q_DEPTH);
  assign q_last_slot = (q_used == CW'(Q_DEPTH - 1)) && !q_pop;

  wpb_target_ctl #(.RETRY_CLKS(RETRY_CLKS), .PAGE_W(PAGE_W)) u_ctl (
    .clk, .rst_n, .bus_start, .bus_dwaddr, .bus_mwi, .bus_dvalid, .bus_last,
    .host_out_pend, .q_room, .q_last_slot, .drain_busy, .would_push, .line_gap,
    .tgt_ack, .tgt_disc, .tgt_retry, .beat_dw, .mode_mwi, .beat_end
  );

  wpb_line_packer u_pack (
    .clk, .rst_n, .beat_take(tgt_ack), .beat_end, .mwi(mode_mwi), .q_room,
    .beat_dw, .beat_data(bus_data), .beat_be(bus_be),
    .would_push, .line_gap, .drain_busy, .push, .push_req
  );

  wpb_req_queue #(.DEPTH(Q_DEPTH)) u_queue (
    .clk, .rst_n, .push, .push_req, .pop(q_pop), .head,
    .not_empty(hreq_valid), .used(q_used)
  );

  assign hreq_line_addr = head.tag;
  assign hreq_data      = head.data;
  assign hreq_mask      = head.mask;
  assign hreq_line      = head.line;

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid && !hreq_ready |=> hreq_valid && $stable(hreq_line_addr)
      && $stable(hreq_mask) && $stable(hreq_line)); // R10
  AST_PARTIAL_ONE_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid && !hreq_line |-> one_chunk(hreq_mask)); // R5
endmodule

// File: tb/wpb_bridge_bench.sv
`timescale 1ns/1ps
module wpb_bridge_bench;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         bus_start = 0, bus_mwi = 0, bus_dvalid = 0, bus_last = 0, host_out_pend = 0;
  logic [29:0]  bus_dwaddr = '0;
  logic [31:0]  bus_data = '0;
  logic [3:0]   bus_be = '0;
  logic         tgt_ack, tgt_disc, tgt_retry, hreq_valid, hreq_line;
  logic         hreq_ready = 0;
  logic [26:0]  hreq_line_addr;
  logic [255:0] hreq_data;
  logic [31:0]  hreq_mask;
  int checks = 0, failures = 0, cyc = 0;

  always #2.5 clk = ~clk;

  wpb_bridge u_wpb_bridge (
    .clk, .rst_n, .bus_start, .bus_dwaddr, .bus_mwi, .bus_dvalid, .bus_data, .bus_be,
    .bus_last, .host_out_pend, .tgt_ack, .tgt_disc, .tgt_retry, .hreq_valid, .hreq_ready,
    .hreq_line_addr, .hreq_data, .hreq_mask, .hreq_line
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] byte_addr, input logic mwi);
    @(negedge clk);
    bus_start = 1; bus_dwaddr = byte_addr[31:2]; bus_mwi = mwi;
    @(posedge clk); #1 bus_start = 0;
  endtask

  task automatic beat(input logic [31:0] d, input logic [3:0] be, input logic last,
                      input logic oreq, output logic a, output logic di, output logic re);
    @(negedge clk);
    bus_dvalid = 1; bus_data = d; bus_be = be; bus_last = last; host_out_pend = oreq;
    #1 a = tgt_ack; di = tgt_disc; re = tgt_retry;
    @(posedge clk); #1 bus_dvalid = 0; bus_last = 0; host_out_pend = 0;
  endtask

  task automatic wait_retry(input logic dv, input int maxc, output int at, output logic acked);
    at = 0; acked = 0;
    for (int n = 1; n <= maxc; n++) begin
      @(negedge clk); bus_dvalid = dv; #1;
      if (tgt_ack) acked = 1;
      if (tgt_retry) at = n;
      @(posedge clk); #1 bus_dvalid = 0;
      if (at != 0) break;
    end
  endtask

  task automatic pop(input string tag, input logic [31:0] byte_addr, input logic [31:0] mask,
                     input logic line, input int dw, input logic [31:0] val);
    int w = 0;
    logic [26:0] sa; logic [31:0] sm;
    @(negedge clk);
    while (!hreq_valid && w < 50) begin @(negedge clk); w++; end
    check({tag, " valid"}, hreq_valid, 1);
    check({tag, " line addr"}, hreq_line_addr, byte_addr[31:5]);
    check({tag, " mask"}, hreq_mask, mask);
    check({tag, " line flag"}, hreq_line, line);
    if (dw >= 0) check({tag, " data"}, hreq_data[dw*32 +: 32], val);
    sa = hreq_line_addr; sm = hreq_mask;
    @(negedge clk);
    check("R10 held while not ready", {sa, sm}, {hreq_line_addr, hreq_mask});
    hreq_ready = 1;
    @(posedge clk); #1 hreq_ready = 0;
  endtask

  task automatic t_reset;
    check("R1 ack after reset", tgt_ack, 0);
    check("R1 disc after reset", tgt_disc, 0);
    check("R1 retry after reset", tgt_retry, 0);
    check("R1 hreq_valid after reset", hreq_valid, 0);
  endtask

  task automatic t_plain;
    logic a, d, r;
    start(32'h100, 0);
    for (int i = 0; i < 4; i++) begin
      beat(32'hA000_0000 + i, 4'hF, i == 3, 0, a, d, r);
      check("R5 plain beat ack", a, 1);
      check("R5 plain beat no disc", d, 0);
    end
    pop("R5 plain chunk0", 32'h100, 32'h0000_00FF, 0, 1, 32'hA000_0001);
    pop("R10 plain chunk1 in order", 32'h100, 32'h0000_FF00, 0, 3, 32'hA000_0003);
  endtask

  task automatic t_line;
    logic a, d, r;
    start(32'h400, 1);
    for (int i = 0; i < 8; i++) begin
      beat(32'hB000_0000 + i, 4'hF, i == 7, 0, a, d, r);
      check("R6 line beat ack", a, 1);
      check("R6 line beat no disc", d, 0);
    end
    pop("R6 full line", 32'h400, 32'hFFFF_FFFF, 1, 5, 32'hB000_0005);
  endtask

  task automatic t_mwi_short;
    logic a, d, r;
    start(32'h500, 1);
    beat(32'hC000_0000, 4'hF, 0, 0, a, d, r);
    beat(32'hC000_0001, 4'h3, 0, 0, a, d, r);
    beat(32'hC000_0002, 4'hF, 1, 0, a, d, r);
    check("R7 short line last beat ack", a, 1);
    pop("R7 leftover chunk0", 32'h500, 32'h0000_003F, 0, 1, 32'hC000_0001);
    pop("R7 leftover chunk1", 32'h500, 32'h0000_0F00, 0, 2, 32'hC000_0002);
  endtask

  task automatic t_outbound;
    logic a, d, r;
    start(32'h700, 0);
    beat(32'hD000_0000, 4'hF, 0, 0, a, d, r);
    check("R3 first beat no disc", d, 0);
    beat(32'hD000_0001, 4'hF, 0, 1, a, d, r);
    check("R3 outbound ack", a, 1);
    check("R3 outbound disc", d, 1);
    beat(32'hD000_0002, 4'hF, 0, 0, a, d, r);
    check("R11 no beat after disc", a, 0);
    pop("R3 outbound chunk", 32'h700, 32'h0000_00FF, 0, 0, 32'hD000_0000);
  endtask

  task automatic t_page;
    logic a, d, r;
    start(32'hFF8, 0);
    beat(32'hE000_0000, 4'hF, 0, 0, a, d, r);
    check("R4 beat before page end no disc", d, 0);
    beat(32'hE000_0001, 4'hF, 0, 0, a, d, r);
    check("R4 page end ack", a, 1);
    check("R4 page end disc", d, 1);
    beat(32'hE000_0002, 4'hF, 0, 0, a, d, r);
    check("R4 next page beat refused", a, 0);
    pop("R4 page chunk", 32'hFE0, 32'hFF00_0000, 0, 7, 32'hE000_0001);
  endtask

  task automatic t_latency_stop;
    logic a, d, r, ak; int at;
    start(32'h900, 0);
    wait_retry(0, 10, at, ak);
    check("R9 no retry in 10 idle cycles", at, 0);
    beat(32'hF000_0000, 4'hF, 0, 0, a, d, r);
    check("R9 late first beat ack", a, 1);
    wait_retry(0, 20, at, ak);
    check("R9 no retry after first beat", at, 0);
    beat(32'hF000_0001, 4'hF, 1, 0, a, d, r);
    check("R9 closing beat ack", a, 1);
    pop("R9 chunk", 32'h900, 32'h0000_00FF, 0, 1, 32'hF000_0001);
    start(32'h980, 0);
    wait_retry(0, 30, at, ak);
    check("R9 timer restarts, retry cycle", at, 16);
  endtask

  task automatic t_full_and_retry;
    logic a, d, r, ak; int at, nacc;
    start(32'h200, 0);
    nacc = 0;
    for (int i = 0; i < 10; i++) begin
      beat(32'h1000_0000 + i, 4'hF, i == 9, 0, a, d, r);
      if (a) nacc++;
      if (i == 7) check("R2 disc on last free entry", d, 1);
      if (i < 7) check("R2 no early disc", d, 0);
    end
    check("R2 beats accepted before queue full", nacc, 8);
    pop("R2 entry0", 32'h200, 32'h0000_00FF, 0, 1, 32'h1000_0001);
    pop("R2 entry1", 32'h200, 32'h0000_FF00, 0, 3, 32'h1000_0003);
    start(32'h60C, 1);
    for (int i = 3; i < 8; i++) begin
      beat(32'h2000_0000 + i, 4'hF, 0, 0, a, d, r);
      check("R7 misaligned line beat ack", a, 1);
      check("R7 disc only at offset 7", d, i == 7);
    end
    start(32'h800, 0);
    wait_retry(1, 30, at, ak);
    check("R7 no beat while drain stalled", ak, 0);
    check("R8 retry cycle", at, 16);
    beat(32'h3000_0000, 4'hF, 0, 0, a, d, r);
    check("R11 no beat after retry", a, 0);
    pop("R10 entry2", 32'h200, 32'h00FF_0000, 0, 5, 32'h1000_0005);
    pop("R10 entry3", 32'h200, 32'hFF00_0000, 0, 7, 32'h1000_0007);
    pop("R7 drain chunk1", 32'h600, 32'h0000_F000, 0, 3, 32'h2000_0003);
    pop("R7 drain chunk2", 32'h600, 32'h00FF_0000, 0, 4, 32'h2000_0004);
    pop("R7 drain chunk3", 32'h600, 32'hFF00_0000, 0, 7, 32'h2000_0007);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1;
    t_plain();
    t_line();
    t_mwi_short();
    t_outbound();
    t_page();
    t_latency_stop();
    t_full_and_retry();
    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule